// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and the status registers of a 32-bit processor core that runs in several operating modes. The sixteen architectural register indices do not all name a single storage word. Some indices name one word that every mode shares. Others name a word that has a separate copy for certain modes. The mode field of the current-status register decides which copy each access reaches. The block translates each 4-bit architectural index into a physical slot and then reads or writes that slot.

There are two combinational read ports and one write port, which writes on the clock edge. The current-status word is read and written through its own port. The saved-status word of the current mode is read and written through a second port. Mode changes are made by writing the current-status word. The block does not contain the exception sequencing that does this; it lies outside, as do instruction decode, the ALU and program-counter update.

Top module: `bankreg_file`

## Requirements
- R1: Indices 0 to 7 address one set of eight words that every mode shares. A write in any mode is seen by a read in any other mode.
- R2: Indices 8 to 12 each have two copies. Fast-interrupt mode (mode field 10001) uses one copy. Every other mode uses the other copy.
- R3: Index 13 has six copies. User mode (10000) and system mode (11111) share one copy. Fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each own one copy.
- R4: Index 14 is banked in the same way as index 13, with six copies. User and system mode share one of them.
- R5: Index 15 is a single word that every mode shares.
- R6: The mode is bits [4:0] of the current-status word. For banking, a mode value other than the seven listed ones is treated as user mode.
- R7: Each of the five exception modes has its own saved-status word. The saved-status port reads and writes the word of the current mode.
- R8: In user mode, system mode or an unlisted mode, the saved-status read returns the current-status word, and a saved-status write changes no stored word.
- R9: A read of a slot that is being written in the same cycle returns the old value. The new value appears in the cycle after the write edge.
- R10: After reset, the current-status word is 0x000000D3 (supervisor mode, both interrupt masks set), and every general and saved-status word is zero.
- R11: A current-status write takes effect at the clock edge. The general and saved-status writes in that same cycle use the mode that was in effect before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Data from read port A (combinational) |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Data from read port B (combinational) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| psr_we | input | 1 | Current-status write enable |
| psr_wdata | input | 32 | New current-status word |
| psr_rdata | output | 32 | Current-status word |
| saved_we | input | 1 | Saved-status write enable for the current mode |
| saved_wdata | input | 32 | New saved-status word |
| saved_rdata | output | 32 | Saved-status word of the current mode, or the current-status word in a mode without one |

## Verification
The main pattern writes a different word, tagged with its mode and index, into all sixteen indices in each of the six banking modes. It then steps through all seven legal modes and reads every index on both ports. The tags show whether shared, two-copy and six-copy indices landed in the correct slot, and whether system mode really shares the user copies. A second pattern uses mode values that are not listed: it shows that such values fall back to the user bank and that writes to the saved status are dropped in those modes. A third pattern writes and reads the same slot in the same cycle, which separates old-value read behaviour from write-through.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int XLEN      = 32;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 5;
  localparam int N_SHARED  = 8;
  localparam int N_HI      = 5;
  localparam int N_BANKS   = 6;
  localparam int N_SAVED   = N_BANKS - 1;

  localparam int BASE_HI_NORM = N_SHARED;
  localparam int BASE_HI_FIQ  = BASE_HI_NORM + N_HI;
  localparam int BASE_SP      = BASE_HI_FIQ + N_HI;
  localparam int BASE_LR      = BASE_SP + N_BANKS;
  localparam int SLOT_PC      = BASE_LR + N_BANKS;
  localparam int N_PHYS       = SLOT_PC + 1;
  localparam int PIDX_W       = $clog2(N_PHYS);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  localparam logic [XLEN-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              has_saved
);

  always_comb begin
    case (mode)
      M_FIQ:   bank = BK_FIQ;
      M_IRQ:   bank = BK_IRQ;
      M_SVC:   bank = BK_SVC;
      M_ABT:   bank = BK_ABT;
      M_UND:   bank = BK_UND;
      default: bank = BK_USR;  // user, system and unlisted codes
    endcase
    has_saved = (bank != BK_USR);
  end

endmodule

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  bank_e             bank,
  output logic [PIDX_W-1:0] pidx
);

  logic [PIDX_W-1:0] hi_base;
  logic [PIDX_W-1:0] hi_off;
  logic [PIDX_W-1:0] bank_off;

  always_comb begin
    hi_base  = (bank == BK_FIQ) ? PIDX_W'(BASE_HI_FIQ) : PIDX_W'(BASE_HI_NORM);
    hi_off   = PIDX_W'(idx) - PIDX_W'(N_SHARED);
    bank_off = PIDX_W'(bank);
    if (idx < IDX_W'(N_SHARED)) begin
      pidx = PIDX_W'(idx);
    end else if (idx < IDX_W'(N_SHARED + N_HI)) begin
      pidx = hi_base + hi_off;
    end else if (idx == IDX_W'(13)) begin
      pidx = PIDX_W'(BASE_SP) + bank_off;
    end else if (idx == IDX_W'(14)) begin
      pidx = PIDX_W'(BASE_LR) + bank_off;
    end else begin
      pidx = PIDX_W'(SLOT_PC);
    end
  end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PIDX_W-1:0]          wr_pidx,
  input  logic [XLEN-1:0]            wr_data,
  input  logic [NRD-1:0][PIDX_W-1:0] rd_pidx,
  output logic [NRD-1:0][XLEN-1:0]   rd_data
);

  logic [N_PHYS-1:0][XLEN-1:0] mem_q;
  logic [N_PHYS-1:0][XLEN-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wr_en) begin
      mem_d[wr_pidx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem_q[rd_pidx[p]];
  end

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_pidx)] == $past(wr_data));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));

endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           bank,
  input  logic            has_saved,
  input  logic            psr_we,
  input  logic [XLEN-1:0] psr_wdata,
  input  logic            saved_we,
  input  logic [XLEN-1:0] saved_wdata,
  output logic [XLEN-1:0] psr_q,
  output logic [XLEN-1:0] saved_rdata
);

  logic [XLEN-1:0]              psr_d;
  logic [N_SAVED-1:0][XLEN-1:0] spsr_q;
  logic [N_SAVED-1:0][XLEN-1:0] spsr_d;
  logic [2:0]                   sp_idx;
  logic                         spsr_en;

  always_comb begin
    sp_idx  = has_saved ? (3'(bank) - 3'd1) : 3'd0;
    spsr_en = saved_we && has_saved;
    psr_d   = psr_we ? psr_wdata : psr_q;
    spsr_d  = spsr_q;
    if (spsr_en) begin
      spsr_d[sp_idx] = saved_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q <= PSR_RESET;
    end else if (psr_we) begin
      psr_q <= psr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spsr_q <= '0;
    end else if (spsr_en) begin
      spsr_q <= spsr_d;
    end
  end

  assign saved_rdata = has_saved ? spsr_q[sp_idx] : psr_q;

  assert_psr_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |=> psr_q == $past(psr_wdata));

  assert_psr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_we |=> $stable(psr_q));

  assert_saved_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (saved_we && has_saved) |=> spsr_q[$past(sp_idx)] == $past(saved_wdata));

  assert_saved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_saved) |=> $stable(spsr_q));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             psr_we,
  input  logic [XLEN-1:0]  psr_wdata,
  output logic [XLEN-1:0]  psr_rdata,
  input  logic             saved_we,
  input  logic [XLEN-1:0]  saved_wdata,
  output logic [XLEN-1:0]  saved_rdata
);

  localparam int NRD    = 2;
  localparam int NPORTS = NRD + 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [XLEN-1:0]                 psr_q;
  bank_e                           bank;
  logic                            has_saved;
  logic [NPORTS-1:0][IDX_W-1:0]    port_idx;
  logic [NPORTS-1:0][PIDX_W-1:0]   port_pidx;
  logic [NRD-1:0][PIDX_W-1:0]      rd_pidx;
  logic [NRD-1:0][XLEN-1:0]        rd_data;

  bankreg_mode_dec u_dec (
    .mode      (psr_q[MODE_W-1:0]),
    .bank      (bank),
    .has_saved (has_saved)
  );

  assign port_idx = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    bankreg_map u_map (
      .idx  (port_idx[p]),
      .bank (bank),
      .pidx (port_pidx[p])
    );
  end

  assign rd_pidx = port_pidx[NRD-1:0];

  bankreg_store #(.NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_pidx (port_pidx[NRD]),
    .wr_data (wr_data),
    .rd_pidx (rd_pidx),
    .rd_data (rd_data)
  );

  bankreg_status u_status (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bank        (bank),
    .has_saved   (has_saved),
    .psr_we      (psr_we),
    .psr_wdata   (psr_wdata),
    .saved_we    (saved_we),
    .saved_wdata (saved_wdata),
    .psr_q       (psr_q),
    .saved_rdata (saved_rdata)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign psr_rdata = psr_q;

  assert_ports_agree_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

  assert_pc_single_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!(wr_en && wr_idx == 4'd15) && rd_a_idx == 4'd15) |=>
      (rd_a_idx != 4'd15) || $stable(rd_a_data));

endmodule

// File: tb/bankreg_file_test.sv
module bankreg_file_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, psr_rdata, saved_rdata;
  logic        wr_en = 1'b0, psr_we = 1'b0, saved_we = 1'b0;
  logic [31:0] wr_data = '0, psr_wdata = '0, saved_wdata = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [31:0] BASE = 32'hC0DE_0000;
  localparam logic [4:0]  MODES [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  always #5 clk = ~clk;

  bankreg_file uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_we(psr_we), .psr_wdata(psr_wdata), .psr_rdata(psr_rdata),
    .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata)
  );

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  // after the fill, shared words hold the undefined-mode write (bank 5, last)
  function automatic logic [31:0] expect_val(input logic [4:0] m, input int idx);
    int b = bank_of(m);
    int w;
    if (idx < 8 || idx == 15)      w = 5;
    else if (idx < 13)             w = (b == 1) ? 1 : 5;
    else                           w = b;
    return BASE | (32'(w) << 8) | 32'(idx);
  endfunction

  function automatic string req_of(input int idx);
    if (idx < 8)   return "R1";
    if (idx < 13)  return "R2";
    if (idx == 13) return "R3";
    if (idx == 14) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_psr(input logic [31:0] v);
    @(negedge clk);
    psr_we = 1'b1; psr_wdata = v;
    @(negedge clk);
    psr_we = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    set_psr({24'h0, 3'b110, m});
  endtask

  task automatic write_reg(input int idx, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_saved(input logic [31:0] v);
    @(negedge clk);
    saved_we = 1'b1; saved_wdata = v;
    @(negedge clk);
    saved_we = 1'b0;
  endtask

  task automatic read_pair(input int ia, input int ib);
    rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
    #1;
  endtask

  task automatic test_reset;
    chk("R10 psr", psr_rdata, 32'h0000_00D3);
    read_pair(0, 13);
    chk("R10 r0", rd_a_data, 32'h0);
    chk("R10 r13", rd_b_data, 32'h0);
    read_pair(15, 8);
    chk("R10 r15", rd_a_data, 32'h0);
    chk("R10 r8", rd_b_data, 32'h0);
    chk("R10 saved", saved_rdata, 32'h0);
  endtask

  task automatic test_bank_fill;
    for (int b = 0; b < 6; b++) begin
      set_mode(MODES[b]);
      for (int i = 0; i < 16; i++) write_reg(i, BASE | (32'(b) << 8) | 32'(i));
    end
    for (int k = 0; k < 7; k++) begin
      set_mode(MODES[k]);
      for (int i = 0; i < 16; i++) begin
        read_pair(i, 15 - i);
        chk(req_of(i), rd_a_data, expect_val(MODES[k], i));
        chk(req_of(15 - i), rd_b_data, expect_val(MODES[k], 15 - i));
      end
    end
  endtask

  task automatic test_saved;
    for (int k = 1; k < 6; k++) begin
      set_mode(MODES[k]);
      write_saved(32'h5A00_0000 | 32'(k));
    end
    for (int k = 1; k < 6; k++) begin
      set_mode(MODES[k]);
      #1;
      chk("R7 saved", saved_rdata, 32'h5A00_0000 | 32'(k));
    end
  endtask

  task automatic test_no_saved;
    logic [4:0] odd [4] = '{5'h10, 5'h1F, 5'h00, 5'h14};
    for (int j = 0; j < 4; j++) begin
      set_mode(odd[j]);
      #1;
      chk("R8 read", saved_rdata, psr_rdata);
      write_saved(32'hDEAD_BEEF);
      chk("R8 read after write", saved_rdata, psr_rdata);
      if (j >= 2) begin
        read_pair(13, 14);
        chk("R6 r13", rd_a_data, expect_val(5'h10, 13));
        chk("R6 r14", rd_b_data, expect_val(5'h10, 14));
        read_pair(9, 9);
        chk("R6 r9", rd_a_data, expect_val(5'h10, 9));
      end
    end
    for (int k = 1; k < 6; k++) begin
      set_mode(MODES[k]);
      #1;
      chk("R8 unchanged", saved_rdata, 32'h5A00_0000 | 32'(k));
    end
  endtask

  task automatic test_rdw;
    set_mode(5'h12);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1234_5678;
    rd_a_idx = 4'd13; rd_b_idx = 4'd3;
    #1;
    chk("R9 old value", rd_a_data, expect_val(5'h12, 13));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R9 new value", rd_a_data, 32'h1234_5678);
    set_mode(5'h13);
    read_pair(13, 13);
    chk("R3 other bank kept", rd_a_data, expect_val(5'h13, 13));
  endtask

  task automatic test_psr;
    set_mode(5'h11);
    // same cycle: psr switches to svc, general write still lands in fiq copy of r10
    @(negedge clk);
    psr_we = 1'b1; psr_wdata = 32'hA000_00D3;
    wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'hFEED_0010;
    saved_we = 1'b1; saved_wdata = 32'h7777_0001;
    @(negedge clk);
    psr_we = 1'b0; wr_en = 1'b0; saved_we = 1'b0;
    #1;
    chk("R11 psr", psr_rdata, 32'hA000_00D3);
    chk("R11 svc saved untouched", saved_rdata, 32'h5A00_0003);
    read_pair(10, 10);
    chk("R11 normal r10 untouched", rd_a_data, expect_val(5'h13, 10));
    set_mode(5'h11);
    read_pair(10, 10);
    chk("R11 fiq r10 written", rd_a_data, 32'hFEED_0010);
    chk("R11 fiq saved written", saved_rdata, 32'h7777_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset;
    test_bank_fill;
    test_saved;
    test_no_saved;
    test_rdw;
    test_psr;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule